// File: doc/BRIEF.md
# Accumulating Sample Wait Counter

The block sits in front of a filter sequencer. It counts filter input samples and tells the sequencer when enough have arrived to produce one output of the whole decimating chain. The count is a running total, not a counter that resets to zero. When the sequencer finishes an output it asks for a decrement, and the block subtracts one of two programmable amounts. Samples that arrived beyond the threshold therefore carry into the next output period.

A write port loads a threshold and two decrement amounts, each 10 bits wide. The threshold is normally the total decimation of the chain; for example, three decimate-by-2 stages need 8 samples. The decrement is normally the same value. A different decrement can be chosen to drop inputs and shift the output timing. The running total is 12 bits wide. It saturates at its maximum and clamps at zero.

Top module: `sample_wait_counter`

## Requirements
- R1: After reset the running total is 0, the threshold is 1, both decrement amounts are 1, and `ready` is low.
- R2: A cycle with `cfg_wr` high loads `cfg_threshold`, `cfg_dec_a` and `cfg_dec_b` (10 bits each) and clears the running total to 0.
- R3: Each cycle with `sample_vld` high adds 1 to the running total.
- R4: `ready` is high exactly when the running total is greater than or equal to the threshold. It follows the total in the cycle after the clock edge that updated it.
- R5: A cycle with `dec_req` high subtracts the first decrement amount when `dec_sel` is 0 and the second decrement amount when `dec_sel` is 1.
- R6: A decrement keeps any excess. After 11 samples and a decrement of 8 with threshold 8, exactly 5 more samples raise `ready`.
- R7: A sample and a decrement in the same cycle change the total to total + 1 − amount.
- R8: When a decrement would take the total below zero, the total becomes 0.
- R9: When an increment would take the total above 4095, the total stays at 4095.
- R10: `cfg_wr` takes priority. A sample or decrement in the same cycle as a write has no effect, and the total is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | One filter input sample this cycle |
| dec_req | input | 1 | Decrement request from the sequencer |
| dec_sel | input | 1 | Decrement amount select: 0 first, 1 second |
| cfg_wr | input | 1 | Load the three fields and clear the total |
| cfg_threshold | input | 10 | Threshold to load |
| cfg_dec_a | input | 10 | First decrement amount to load |
| cfg_dec_b | input | 10 | Second decrement amount to load |
| ready | output | 1 | Total is greater than or equal to the threshold |

## Verification
Saturation is the hardest case to reach from the ports. The threshold can be at most 1023, so a total pinned at 4095 looks the same at `ready` as any total above 1023. To expose it, the stimulus sends more than 4095 samples and then applies four decrements of 1023. With a threshold of 4 this leaves a total of 3, which is visible at `ready` and differs from what a wrapped total would give. The rest of the testing is a sweep over small thresholds and decrement pairs, driven by a pseudo-random mix of samples and decrements. Each cycle is compared against an arithmetic model of the total.

// File: rtl/wait_pkg.sv
package wait_pkg;
   typedef enum logic {
      DEC_SEL_A = 1'b0,
      DEC_SEL_B = 1'b1
   } dec_sel_e;
endpackage

// File: rtl/wait_cfg_reg.sv
module wait_cfg_reg #(
   parameter int FIELD_W      = 10,
   parameter int RESET_THRESH = 1,
   parameter int RESET_DEC    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [FIELD_W-1:0] wr_thresh,
   input  logic [FIELD_W-1:0] wr_dec_a,
   input  logic [FIELD_W-1:0] wr_dec_b,
   output logic [FIELD_W-1:0] thresh,
   output logic [FIELD_W-1:0] dec_a,
   output logic [FIELD_W-1:0] dec_b
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thresh <= FIELD_W'(RESET_THRESH);
         dec_a  <= FIELD_W'(RESET_DEC);
         dec_b  <= FIELD_W'(RESET_DEC);
      end else if (wr) begin
         thresh <= wr_thresh;
         dec_a  <= wr_dec_a;
         dec_b  <= wr_dec_b;
      end
   end
endmodule

// File: rtl/wait_dec_mux.sv
module wait_dec_mux #(
   parameter int FIELD_W = 10
) (
   input  logic               dec_req,
   input  wait_pkg::dec_sel_e dec_sel,
   input  logic [FIELD_W-1:0] dec_a,
   input  logic [FIELD_W-1:0] dec_b,
   output logic [FIELD_W-1:0] dec_amt
);
   always_comb begin
      if (!dec_req)                          dec_amt = '0;
      else if (dec_sel == wait_pkg::DEC_SEL_B) dec_amt = dec_b;
      else                                   dec_amt = dec_a;
   end
endmodule

// File: rtl/wait_accum.sv
module wait_accum #(
   parameter int ACC_W    = 12,
   parameter int FIELD_W  = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               inc,
   input  logic [FIELD_W-1:0] dec_amt,
   output logic [ACC_W-1:0]   count
);
   localparam int SUM_W = ACC_W + 2;
   localparam logic [SUM_W-1:0] TOP = SUM_W'((1 << ACC_W) - 1);

   logic [SUM_W-1:0] sum;
   logic             neg;
   logic [ACC_W-1:0] next_count;

   assign sum = SUM_W'(count) + SUM_W'(inc) - SUM_W'(dec_amt);
   assign neg = sum[SUM_W-1];

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (neg)            next_count = '0;
            else if (sum > TOP) next_count = TOP[ACC_W-1:0];
            else                next_count = sum[ACC_W-1:0];
         end
      end else begin : g_wrap
         always_comb begin
            if (neg) next_count = '0;
            else     next_count = sum[ACC_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else            count <= next_count;
   end
endmodule

// File: rtl/wait_compare.sv
module wait_compare #(
   parameter int ACC_W   = 12,
   parameter int FIELD_W = 10
) (
   input  logic [ACC_W-1:0]   count,
   input  logic [FIELD_W-1:0] thresh,
   output logic               ready
);
   assign ready = (count >= ACC_W'(thresh));
endmodule

// File: rtl/sample_wait_counter.sv
module sample_wait_counter #(
   parameter int FIELD_W      = 10,
   parameter int ACC_W        = 12,
   parameter bit SATURATE     = 1'b1,
   parameter int RESET_THRESH = 1,
   parameter int RESET_DEC    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_vld,
   input  logic               dec_req,
   input  logic               dec_sel,
   input  logic               cfg_wr,
   input  logic [FIELD_W-1:0] cfg_threshold,
   input  logic [FIELD_W-1:0] cfg_dec_a,
   input  logic [FIELD_W-1:0] cfg_dec_b,
   output logic               ready
);
   if (ACC_W <= FIELD_W) begin : g_bad_acc_w
      $error("ACC_W must exceed FIELD_W");
   end
   if (RESET_THRESH >= (1 << FIELD_W) || RESET_DEC >= (1 << FIELD_W)) begin : g_bad_reset
      $error("reset field values must fit FIELD_W");
   end

   logic [FIELD_W-1:0] thr_q, dec_a_q, dec_b_q, dec_amt;
   logic [ACC_W-1:0]   acc_count;
   wait_pkg::dec_sel_e sel_e;

   assign sel_e = wait_pkg::dec_sel_e'(dec_sel);

   wait_cfg_reg #(.FIELD_W(FIELD_W), .RESET_THRESH(RESET_THRESH), .RESET_DEC(RESET_DEC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
      .wr_thresh(cfg_threshold), .wr_dec_a(cfg_dec_a), .wr_dec_b(cfg_dec_b),
      .thresh(thr_q), .dec_a(dec_a_q), .dec_b(dec_b_q)
   );

   wait_dec_mux #(.FIELD_W(FIELD_W)) u_mux (
      .dec_req(dec_req), .dec_sel(sel_e), .dec_a(dec_a_q), .dec_b(dec_b_q), .dec_amt(dec_amt)
   );

   wait_accum #(.ACC_W(ACC_W), .FIELD_W(FIELD_W), .SATURATE(SATURATE)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .inc(sample_vld),
      .dec_amt(dec_amt), .count(acc_count)
   );

   wait_compare #(.ACC_W(ACC_W), .FIELD_W(FIELD_W)) u_cmp (
      .count(acc_count), .thresh(thr_q), .ready(ready)
   );
endmodule

// File: rtl/wait_counter_checks.sv
module wait_counter_checks #(
   parameter int FIELD_W = 10,
   parameter int ACC_W   = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sample_vld,
   input logic               dec_req,
   input logic               dec_sel,
   input logic               cfg_wr,
   input logic               ready,
   input logic [ACC_W-1:0]   count,
   input logic [FIELD_W-1:0] dec_a,
   input logic [FIELD_W-1:0] dec_b
);
   localparam logic [ACC_W-1:0] TOP = '1;

   assert_clear_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (count == '0));

   assert_increment_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && !dec_req && !cfg_wr && count != TOP) |=> (count == $past(count) + 1'b1));

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_vld && !dec_req && !cfg_wr) |=> $stable(count));

   assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(sample_vld) || $past(cfg_wr)));

   assert_sub_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_req && !dec_sel && !sample_vld && !cfg_wr && count >= ACC_W'(dec_a))
      |=> (count == $past(count) - ACC_W'($past(dec_a))));

   assert_clamp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_req && dec_sel && !sample_vld && !cfg_wr && count < ACC_W'(dec_b)) |=> (count == '0));

   assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && !dec_req && !cfg_wr && count == TOP) |=> (count == TOP));
endmodule

bind sample_wait_counter wait_counter_checks #(.FIELD_W(FIELD_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .dec_req(dec_req), .dec_sel(dec_sel),
   .cfg_wr(cfg_wr), .ready(ready), .count(acc_count), .dec_a(dec_a_q), .dec_b(dec_b_q)
);

// File: tb/sample_wait_counter_test.sv
module sample_wait_counter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_vld = 1'b0, dec_req = 1'b0, dec_sel = 1'b0, cfg_wr = 1'b0;
   logic [9:0] cfg_threshold = '0, cfg_dec_a = '0, cfg_dec_b = '0;
   logic       ready;

   int checks = 0;
   int errors = 0;
   int m_cnt = 0, m_thr = 1, m_da = 1, m_db = 1;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   sample_wait_counter uut (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .dec_req(dec_req), .dec_sel(dec_sel),
      .cfg_wr(cfg_wr), .cfg_threshold(cfg_threshold), .cfg_dec_a(cfg_dec_a),
      .cfg_dec_b(cfg_dec_b), .ready(ready)
   );

   task automatic check(input logic exp, input string tag);
      checks++;
      if (ready !== exp) begin
         errors++;
         $display("FAIL %s ready=%0b expected=%0b (model total %0d thr %0d)", tag, ready, exp, m_cnt, m_thr);
      end
   endtask

   task automatic step(input logic s, input logic d, input logic sel, input logic wr,
                       input int thr, input int da, input int db, input string force_tag);
      int    raw;
      string tag;
      @(negedge clk);
      sample_vld = s; dec_req = d; dec_sel = sel; cfg_wr = wr;
      cfg_threshold = 10'(thr); cfg_dec_a = 10'(da); cfg_dec_b = 10'(db);
      @(posedge clk);
      #1;
      raw = m_cnt + int'(s) - (d ? (sel ? m_db : m_da) : 0);
      if (wr)                  tag = (s || d) ? "R10" : "R2";
      else if (raw < 0)        tag = "R8";
      else if (raw > 4095)     tag = "R9";
      else if (s && d)         tag = "R7";
      else if (d)              tag = "R5";
      else if (s)              tag = "R3";
      else                     tag = "R4";
      if (force_tag != "") tag = force_tag;
      if (wr) begin
         m_cnt = 0; m_thr = thr; m_da = da; m_db = db;
      end else begin
         m_cnt = (raw < 0) ? 0 : ((raw > 4095) ? 4095 : raw);
      end
      check(m_cnt >= m_thr, tag);
      sample_vld = 1'b0; dec_req = 1'b0; cfg_wr = 1'b0;
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, tag);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check(1'b0, "R1");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check(1'b0, "R1");
      // default threshold 1: one sample raises ready, default decrement 1 drops it
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R1");
      step(1'b0, 1'b1, 1'b1, 1'b0, 0, 0, 0, "R1");

      // excess kept across a decrement: threshold 8, decrement 8
      step(1'b0, 1'b0, 1'b0, 1'b1, 8, 8, 3, "R2");
      for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "");
      step(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R6");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R6");
      // second decrement amount 3 from 8 -> 5
      step(1'b0, 1'b1, 1'b1, 1'b0, 0, 0, 0, "R5");

      // sweep small thresholds and decrement pairs with mixed traffic
      for (int thr = 0; thr < 16; thr++) begin
         for (int da = 0; da < 16; da++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, thr, da, (thr * 3 + da) % 16, "");
            for (int k = 0; k < 24; k++) begin
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               step(lfsr[0] | lfsr[5], lfsr[3:2] == 2'b00, lfsr[7], lfsr[11:4] == 8'h00,
                    int'(lfsr[9:6]), int'(lfsr[13:10]), int'(lfsr[15:12]), "");
            end
            idle("");
         end
      end

      // write wins over a same-cycle sample and decrement
      step(1'b0, 1'b0, 1'b0, 1'b1, 0, 5, 5, "R2");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R3");
      step(1'b1, 1'b1, 1'b0, 1'b1, 1, 5, 5, "R10");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R10");
      // clamp at zero: total 1, decrement 5, then one sample must reach threshold 1
      step(1'b0, 1'b1, 1'b1, 1'b0, 0, 0, 0, "R8");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R8");

      // saturation: 4200 samples, four decrements of 1023 leave 3
      step(1'b0, 1'b0, 1'b0, 1'b1, 4, 1023, 1023, "R2");
      for (int i = 0; i < 4200; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, i[0], 1'b0, 0, 0, 0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R9");
      // combined sample and decrement: 4 + 1 - 1023 clamps; retest with small amount
      step(1'b0, 1'b0, 1'b0, 1'b1, 2, 2, 1, "R2");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R3");
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R4");
      step(1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 0, "R7");
      step(1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 0, "R7");
      idle("R4");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule